// File: doc/BRIEF.md
# Oscillator Noise Sampler and Collector

This block gathers raw entropy from a bank of free-running oscillator inputs and turns it into 128-bit random results. On every enabled clock cycle the sampled level of each selected oscillator is combined by XOR into one mixed bit. A programmable number of consecutive mixed bits is then XOR-folded into a single collected bit. That bit is shifted into a history register.

Collected bits are counted in blocks of 512 bits, which is 64 eight-bit samples. When the programmed number of blocks has been gathered, the newest 128 collected bits are latched as the result and a ready flag is raised. The result is held, and collection stops, until the consumer pulses an acknowledge.

No conditioning function is applied. The result is taken directly from the collected bits. The sample and block counts are meant to be changed only while the global enable is low.

Top module: `noise_collector`

## Requirements
- R1: The mixed bit of a cycle is the XOR of `osc_bits[k]` over every k with `osc_en[k]` = 1. An oscillator with its enable bit at 0 has no effect on the result.
- R2: Each collected bit is the XOR of S consecutive mixed bits, where S is the value of `sample_cfg`.
- R3: A `sample_cfg` of 0 folds 2^SCNT_W mixed bits per collected bit. With the default SCNT_W of 16 this is 65536.
- R4: With `en` high, `ready` rises after exactly S × BLOCK_BITS × B enabled cycles, where B is the value of `block_cfg`.
- R4 (result layout): `result[0]` is the newest collected bit and `result[127]` is the oldest of the last 128. Word k of the result is `result[32k+31:32k]`.
- R5: A `block_cfg` of 0 selects 2^BLK_W blocks, which is 256 by default.
- R6: While `ready` is high and `ack` is low, `ready` stays high, `result` is stable, and no bits are collected.
- R7: `ack` while `ready` is high clears `ready` on the next clock edge, and the following result needs a full new count of cycles. `ack` while `ready` is low has no effect.
- R8: A cycle with `en` low clears the fold, bit and block counters and the history register, and `ready` cannot rise in that cycle. `ready` and `result` are not changed by `en`.
- R9: After reset, `ready` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global collection enable; low clears collection state |
| osc_en | input | 24 | Per-oscillator enable mask |
| osc_bits | input | 24 | Sampled oscillator levels, one per oscillator |
| sample_cfg | input | 16 | Mixed bits folded per collected bit (0 means 65536) |
| block_cfg | input | 8 | 512-bit blocks per result (0 means 256) |
| ack | input | 1 | Acknowledge pulse that clears `ready` |
| ready | output | 1 | Result valid flag |
| result | output | 128 | Latest 128 collected bits, arranged as four 32-bit words |

## Verification
The critical same-cycle collision is the enable being dropped in exactly the cycle that would deliver the final bit of the final block. The bench runs the collector for one cycle short of a full count and then lowers `en` for one cycle. It judges that `ready` stays low and that a whole fresh count is then needed before the result appears.

A related overlap is an `ack` pulse arriving in the middle of a collection. The bench expects the completion cycle to be unchanged by that pulse.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int RES_W  = 128;
  localparam int WORD_W = 32;
  localparam int N_WORD = RES_W / WORD_W;
  typedef logic [RES_W-1:0] result_t;
endpackage

// File: rtl/nc_fold.sv
module nc_fold #(
  parameter int N_OSC  = 24,
  parameter int SCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [N_OSC-1:0]  osc_en,
  input  logic [N_OSC-1:0]  osc_bits,
  input  logic [SCNT_W-1:0] sample_cfg,
  output logic              bit_vld,
  output logic              bit_val
);
  localparam int CNT_W = SCNT_W + 1;

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             acc_q, acc_d;
  logic             mixed;
  logic             last;
  logic             upd;

  assign mixed = ^(osc_bits & osc_en);
  assign lim   = (sample_cfg == '0) ? {1'b1, {SCNT_W{1'b0}}} : {1'b0, sample_cfg};
  assign last  = ((cnt_q + CNT_W'(1)) == lim);
  assign upd   = clr | run;

  always_comb begin
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    bit_vld = 1'b0;
    bit_val = acc_q ^ mixed;
    if (clr) begin
      cnt_d = '0;
      acc_d = 1'b0;
    end else if (run) begin
      if (last) begin
        bit_vld = 1'b1;
        cnt_d   = '0;
        acc_d   = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        acc_d = acc_q ^ mixed;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R2: the fold counter never reaches the programmed fold length
  p_fold_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim);

  // R8: a clear leaves the fold counter at zero
  p_fold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/nc_collect.sv
module nc_collect #(
  parameter int BLOCK_BITS = 512,
  parameter int BLK_W      = 8,
  parameter int RES_W      = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic [BLK_W-1:0] block_cfg,
  output logic             done,
  output logic [RES_W-1:0] hist_nx
);
  localparam int BIT_W = $clog2(BLOCK_BITS);
  localparam int BC_W  = BLK_W + 1;

  logic [BIT_W-1:0] bits_q, bits_d;
  logic [BC_W-1:0]  blk_q, blk_d;
  logic [BC_W-1:0]  blim;
  logic [RES_W-1:0] hist_q, hist_d;
  logic             blk_end;
  logic             upd;

  assign blim    = (block_cfg == '0) ? {1'b1, {BLK_W{1'b0}}} : {1'b0, block_cfg};
  assign blk_end = (bits_q == BIT_W'(BLOCK_BITS - 1));
  assign hist_nx = {hist_q[RES_W-2:0], bit_val};
  assign done    = bit_vld & blk_end & ((blk_q + BC_W'(1)) == blim);
  assign upd     = clr | bit_vld;

  always_comb begin
    bits_d = bits_q;
    blk_d  = blk_q;
    hist_d = hist_q;
    if (clr) begin
      bits_d = '0;
      blk_d  = '0;
      hist_d = '0;
    end else if (bit_vld) begin
      hist_d = hist_nx;
      if (blk_end) begin
        bits_d = '0;
        blk_d  = done ? '0 : blk_q + BC_W'(1);
      end else begin
        bits_d = bits_q + BIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      blk_q  <= '0;
      hist_q <= '0;
    end else if (upd) begin
      bits_q <= bits_d;
      blk_q  <= blk_d;
      hist_q <= hist_d;
    end
  end

  // R4: the block counter stays below the programmed block count
  p_blk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q < blim);

  // R8: a clear empties the history register
  p_hist_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_q == '0));
endmodule

// File: rtl/noise_collector.sv
module noise_collector #(
  parameter int N_OSC      = 24,
  parameter int SCNT_W     = 16,
  parameter int BLK_W      = 8,
  parameter int BLOCK_BITS = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [N_OSC-1:0]         osc_en,
  input  logic [N_OSC-1:0]         osc_bits,
  input  logic [SCNT_W-1:0]        sample_cfg,
  input  logic [BLK_W-1:0]         block_cfg,
  input  logic                     ack,
  output logic                     ready,
  output logic [nc_pkg::RES_W-1:0] result
);
  import nc_pkg::*;

  logic    run, clr;
  logic    bit_vld, bit_val;
  logic    done;
  result_t hist_nx;
  logic    ready_q, ready_d;
  result_t res_q;
  logic    rdy_upd;

  assign clr = ~en;
  assign run = en & ~ready_q;

  nc_fold #(.N_OSC(N_OSC), .SCNT_W(SCNT_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .osc_en(osc_en), .osc_bits(osc_bits), .sample_cfg(sample_cfg),
    .bit_vld(bit_vld), .bit_val(bit_val)
  );

  nc_collect #(.BLOCK_BITS(BLOCK_BITS), .BLK_W(BLK_W), .RES_W(RES_W)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bit_vld(bit_vld), .bit_val(bit_val), .block_cfg(block_cfg),
    .done(done), .hist_nx(hist_nx)
  );

  always_comb begin
    ready_d = ready_q;
    if (ready_q && ack) ready_d = 1'b0;
    else if (done)      ready_d = 1'b1;
  end

  assign rdy_upd = (ready_q & ack) | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else if (rdy_upd) begin
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (done) begin
      res_q <= hist_nx;
    end
  end

  assign ready  = ready_q;
  assign result = res_q;

  // R6: an unacknowledged result is held unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !ack) |=> (ready_q && $stable(res_q)));

  // R6: no completion is reported while a result is pending
  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !done);

  // R7: an acknowledge of a pending result clears the flag
  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && ack) |=> !ready_q);

  // R8: the flag can only rise from a cycle with the enable high
  p_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(en));
endmodule

// File: tb/noise_collector_tb.sv
module noise_collector_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [23:0]  osc_en, osc_bits;
  logic         en0, en1, ack0, ack1;
  logic [15:0]  scfg0;
  logic [3:0]   scfg1;
  logic [7:0]   bcfg0;
  logic [1:0]   bcfg1;
  logic         rdy0, rdy1;
  logic [127:0] res0, res1;

  noise_collector u_dut (
    .clk(clk), .rst_n(rst_n), .en(en0), .osc_en(osc_en), .osc_bits(osc_bits),
    .sample_cfg(scfg0), .block_cfg(bcfg0), .ack(ack0), .ready(rdy0), .result(res0)
  );

  noise_collector #(.SCNT_W(4), .BLK_W(2), .BLOCK_BITS(64)) u_small (
    .clk(clk), .rst_n(rst_n), .en(en1), .osc_en(osc_en), .osc_bits(osc_bits),
    .sample_cfg(scfg1), .block_cfg(bcfg1), .ack(ack1), .ready(rdy1), .result(res1)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  int           fc[2], nb[2], blk[2];
  bit           acc[2], mrdy[2];
  logic [127:0] hist[2], mres[2];

  function automatic logic [23:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:7];
  endfunction

  function automatic int slim(input int i);
    if (i == 0) return (scfg0 == 0) ? 65536 : int'(scfg0);
    return (scfg1 == 0) ? 16 : int'(scfg1);
  endfunction

  function automatic int blim(input int i);
    if (i == 0) return (bcfg0 == 0) ? 256 : int'(bcfg0);
    return (bcfg1 == 0) ? 4 : int'(bcfg1);
  endfunction

  task automatic mstep(input int i, input bit e, input bit a, input logic [23:0] b);
    bit mixed;
    bit was;
    bit cb;
    int bbits;
    mixed = ^(b & osc_en);
    was   = mrdy[i];
    bbits = (i == 0) ? 512 : 64;
    if (!e) begin
      fc[i] = 0; acc[i] = 0; nb[i] = 0; blk[i] = 0; hist[i] = '0;
    end else if (!was) begin
      if (fc[i] + 1 == slim(i)) begin
        cb = acc[i] ^ mixed;
        acc[i] = 0;
        fc[i] = 0;
        hist[i] = {hist[i][126:0], cb};
        if (nb[i] + 1 == bbits) begin
          nb[i] = 0;
          if (blk[i] + 1 == blim(i)) begin
            blk[i] = 0;
            mrdy[i] = 1;
            mres[i] = hist[i];
          end else begin
            blk[i] = blk[i] + 1;
          end
        end else begin
          nb[i] = nb[i] + 1;
        end
      end else begin
        acc[i] = acc[i] ^ mixed;
        fc[i] = fc[i] + 1;
      end
    end
    if (was && a) mrdy[i] = 0;
  endtask

  // one clock cycle: drive at a negedge, model the next posedge, return at the next negedge
  task automatic step();
    logic [23:0] b;
    b = rnd();
    osc_bits = b;
    mstep(0, en0, ack0, b);
    mstep(1, en1, ack1, b);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic chk(input int i, input string req);
    logic         r;
    logic [127:0] v;
    r = (i == 0) ? rdy0 : rdy1;
    v = (i == 0) ? res0 : res1;
    checks++;
    if (r !== mrdy[i] || v !== mres[i]) begin
      errors++;
      $display("FAIL %s inst%0d: ready=%0b result=%h expected ready=%0b result=%h",
               req, i, r, v, mrdy[i], mres[i]);
    end
  endtask

  task automatic ack_pulse(input int i);
    if (i == 0) ack0 = 1'b1; else ack1 = 1'b1;
    step();
    ack0 = 1'b0;
    ack1 = 1'b0;
  endtask

  task automatic t_reset();
    chk(0, "R9");
    chk(1, "R9");
  endtask

  task automatic t_basic();
    int n;
    osc_en = 24'h00F0F1; scfg0 = 16'd3; bcfg0 = 8'd1;
    en0 = 1'b1;
    n = 3 * 512;
    run(n - 1);
    chk(0, "R4 early");
    step();
    chk(0, "R4 R2 R1 complete");
  endtask

  task automatic t_hold();
    run(25);
    chk(0, "R6 hold");
    run(300);
    chk(0, "R6 pause");
  endtask

  task automatic t_ack();
    ack_pulse(0);
    chk(0, "R7 clear");
    run(700);
    ack_pulse(0);           // ignored, ready is low
    run(1536 - 702);
    chk(0, "R7 ignore");
    step();
    chk(0, "R7 restart");
  endtask

  task automatic t_en_drop();
    ack_pulse(0);
    run(1536 - 1);
    en0 = 1'b0;
    step();
    chk(0, "R8 drop at completion");
    en0 = 1'b1;
    run(1536 - 1);
    chk(0, "R8 fresh count");
    step();
    chk(0, "R8 complete");
    ack_pulse(0);
  endtask

  task automatic t_mask();
    en0 = 1'b0;
    step();
    osc_en = 24'h800001; scfg0 = 16'd5; bcfg0 = 8'd2;
    en0 = 1'b1;
    run(5 * 512 * 2);
    chk(0, "R1 R2 mask and fold");
    ack_pulse(0);
    en0 = 1'b0;
    step();
  endtask

  task automatic t_zero_sample();
    scfg1 = 4'd0; bcfg1 = 2'd1;
    en1 = 1'b1;
    run(16 * 64 - 1);
    chk(1, "R3 early");
    step();
    chk(1, "R3 complete");
    ack_pulse(1);
    en1 = 1'b0;
    step();
  endtask

  task automatic t_zero_block();
    scfg1 = 4'd1; bcfg1 = 2'd0;
    en1 = 1'b1;
    run(4 * 64 - 1);
    chk(1, "R5 early");
    step();
    chk(1, "R5 complete");
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en0 = 1'b0; en1 = 1'b0; ack0 = 1'b0; ack1 = 1'b0;
    osc_en = '0; osc_bits = '0;
    scfg0 = 16'd1; scfg1 = 4'd1; bcfg0 = 8'd1; bcfg1 = 2'd1;
    for (int i = 0; i < 2; i++) begin
      fc[i] = 0; nb[i] = 0; blk[i] = 0; acc[i] = 0; mrdy[i] = 0;
      hist[i] = '0; mres[i] = '0;
    end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_ack();
    t_en_drop();
    t_mask();
    t_zero_sample();
    t_zero_block();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule